// File: doc/BRIEF.md
# FM Register Trap with Instant Timer Status

This block sits on the host bus in front of a four-port FM synthesizer register window that has no real synthesizer behind it. Even offsets act as index ports and odd offsets as data ports. The block keeps the most recent index byte and the most recent data byte. It also holds a one-byte timer status value that software polls to find the synthesizer. When software starts a timer through the timer control register, the block raises the matching overflow flag at once, without counting. After each trapped data write it can also raise a one-cycle NMI or SMI request, so that a handler can act on the access.

Reads return the status byte at offset 0 and zero at every other offset. The enable bit and the SMI/NMI select bit come from control-register inputs.

Top module: `fmtrap_top`

## Requirements
- R1: After reset, the status byte, the latched index and the latched data are all 0x00, and neither request output is high.
- R2: A read at offset 0 (address 2'b00) returns the status byte. A read at offsets 1, 2 or 3 returns 0x00. While the read strobe is low, the read data is 0x00.
- R3: A write to an even offset (address bit 0 = 0) latches the byte as the index. A write to an odd offset (address bit 0 = 1) latches the byte as data. Each latch becomes visible on the clock edge that captures the write.
- R4: The status byte changes only on a data write at offset 1 (address 2'b01) while the latched index is 0x04. A data write at offset 3 with index 0x04 leaves it unchanged.
- R5: In a status-updating write, data bit 7 set clears the status byte before the other rules of that same write apply.
- R6: In a status-updating write, data bit 0 = 1 with data bit 6 = 0 sets status bit 6. Data bit 1 = 1 with data bit 5 = 0 sets status bit 5. Without a clear, set bits stay set.
- R7: Whenever status bit 6 or status bit 5 is set, status bit 7 is set as well.
- R8: A data write (odd offset) with control bit 0 = 1 produces a one-cycle pulse in the cycle after the write. The pulse goes on `irq_smi` when control bit 2 = 1 and on `irq_nmi` when it is 0. Index writes and writes with control bit 0 = 0 produce no pulse.
- R9: Data writes while the latched index is any value other than 0x04 change only the data latch, never the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Port offset within the window |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| cfg_ctrl | input | 8 | Control byte: bit 0 request enable, bit 2 SMI select |
| bus_rdata | output | 8 | Read data |
| irq_nmi | output | 1 | NMI request pulse |
| irq_smi | output | 1 | SMI request pulse |
| trap_index | output | 8 | Last latched index byte |
| trap_data | output | 8 | Last latched data byte |
| timer_status | output | 8 | Current status byte |

## Verification
The bench uses the default parameters: an 8-bit data path and 0x04 as the timer index. With one byte of data, every data value fits in a single sweep. All 256 values are written to the timer index twice, once starting from a cleared status and once from an accumulated status, so every combination of clear, start and mask bits is compared against an arithmetic model. A second sweep walks all 256 index values with a timer-start pattern, to confirm that only 0x04 reaches the status. A third sweep covers all eight combinations of the low control bits, checking pulse routing and pulse width.

// File: rtl/fmtrap_pkg.sv
package fmtrap_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int CLR_BIT   = 7;
    localparam int SUM_BIT   = 7;
    localparam int T1_OVF    = 6;
    localparam int T2_OVF    = 5;
    localparam int T1_START  = 0;
    localparam int T2_START  = 1;
    localparam int T1_MASK   = 6;
    localparam int T2_MASK   = 5;
    localparam int CTL_EN    = 0;
    localparam int CTL_SMI   = 2;

    typedef struct packed {
        logic idx_wr;
        logic dat_wr;
        logic dat_low;
        logic rd_base;
    } acc_t;
endpackage

// File: rtl/fmtrap_decode.sv
module fmtrap_decode
    import fmtrap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_t              acc
);
    always_comb begin
        acc         = '0;
        acc.idx_wr  = wr && !addr[0];
        acc.dat_wr  = wr && addr[0];
        acc.dat_low = wr && addr[0] && !addr[1];
        acc.rd_base = rd && (addr == '0);
    end
endmodule

// File: rtl/fmtrap_latch.sv
module fmtrap_latch
    import fmtrap_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_t         acc,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] index_o,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic [W-1:0] idx;
        logic [W-1:0] dat;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (acc.idx_wr) lat_d.idx = wdata;
        if (acc.dat_wr) lat_d.dat = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign index_o = lat_q.idx;
    assign data_o  = lat_q.dat;
endmodule

// File: rtl/fmtrap_status.sv
module fmtrap_status
    import fmtrap_pkg::*;
#(
    parameter int           W         = DATA_W,
    parameter logic [W-1:0] TIMER_IDX = 8'h04
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_t         acc,
    input  logic [W-1:0] index_q,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status_o
);
    logic [W-1:0] st_d, st_q;
    logic         hit;

    always_comb begin
        hit  = acc.dat_low && (index_q == TIMER_IDX);
        st_d = st_q;
        if (hit) begin
            if (wdata[CLR_BIT]) st_d = '0;
            if (wdata[T1_START] && !wdata[T1_MASK]) st_d[T1_OVF] = 1'b1;
            if (wdata[T2_START] && !wdata[T2_MASK]) st_d[T2_OVF] = 1'b1;
            if (st_d[T1_OVF] || st_d[T2_OVF]) st_d[SUM_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q;
endmodule

// File: rtl/fmtrap_irq.sv
module fmtrap_irq
    import fmtrap_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_t         acc,
    input  logic [W-1:0] ctrl,
    output logic         nmi_o,
    output logic         smi_o
);
    typedef struct packed {
        logic nmi;
        logic smi;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d = '0;
        if (acc.dat_wr && ctrl[CTL_EN]) begin
            if (ctrl[CTL_SMI]) req_d.smi = 1'b1;
            else               req_d.nmi = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign nmi_o = req_q.nmi;
    assign smi_o = req_q.smi;
endmodule

// File: rtl/fmtrap_top.sv
module fmtrap_top
    import fmtrap_pkg::*;
#(
    parameter logic [DATA_W-1:0] TIMER_IDX = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] cfg_ctrl,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_nmi,
    output logic              irq_smi,
    output logic [DATA_W-1:0] trap_index,
    output logic [DATA_W-1:0] trap_data,
    output logic [DATA_W-1:0] timer_status
);
    acc_t acc;

    fmtrap_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .acc  (acc)
    );

    fmtrap_latch #(.W(DATA_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wdata   (bus_wdata),
        .index_o (trap_index),
        .data_o  (trap_data)
    );

    fmtrap_status #(.W(DATA_W), .TIMER_IDX(TIMER_IDX)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .index_q  (trap_index),
        .wdata    (bus_wdata),
        .status_o (timer_status)
    );

    fmtrap_irq #(.W(DATA_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .ctrl  (cfg_ctrl),
        .nmi_o (irq_nmi),
        .smi_o (irq_smi)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc.rd_base) bus_rdata = timer_status;
    end
endmodule

// File: rtl/fmtrap_chk.sv
module fmtrap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] cfg_ctrl,
    input logic [7:0] bus_rdata,
    input logic       irq_nmi,
    input logic       irq_smi,
    input logic [7:0] trap_index,
    input logic [7:0] timer_status
);
    AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 2'b00) |-> (bus_rdata == 8'h00)); // R2
    AST_RD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'b00) |-> (bus_rdata == timer_status)); // R2
    AST_IDX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[0]) |=> (trap_index == $past(bus_wdata))); // R3
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'b01 && trap_index == 8'h04) |=> $stable(timer_status)); // R4
    AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'b01 && trap_index == 8'h04 && bus_wdata[7] && bus_wdata[1:0] == 2'b00)
        |=> (timer_status == 8'h00)); // R5
    AST_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_status[6] || timer_status[5]) |-> timer_status[7]); // R7
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({irq_nmi, irq_smi}) <= 1); // R8
    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi |-> $past(bus_wr && bus_addr[0] && cfg_ctrl[0] && !cfg_ctrl[2])); // R8
    AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_smi |-> $past(bus_wr && bus_addr[0] && cfg_ctrl[0] && cfg_ctrl[2])); // R8
endmodule

bind fmtrap_top fmtrap_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .cfg_ctrl     (cfg_ctrl),
    .bus_rdata    (bus_rdata),
    .irq_nmi      (irq_nmi),
    .irq_smi      (irq_smi),
    .trap_index   (trap_index),
    .timer_status (timer_status)
);

// File: tb/sim_fmtrap_top.sv
module sim_fmtrap_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] cfg_ctrl = '0;
    logic [7:0] bus_rdata, trap_index, trap_data, timer_status;
    logic       irq_nmi, irq_smi;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model;

    always #5 clk = ~clk;

    fmtrap_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .cfg_ctrl(cfg_ctrl),
        .bus_rdata(bus_rdata), .irq_nmi(irq_nmi), .irq_smi(irq_smi),
        .trap_index(trap_index), .trap_data(trap_data), .timer_status(timer_status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] next_status(input logic [7:0] s, input logic [7:0] d);
        logic [7:0] r;
        r = d[7] ? 8'h00 : s;
        if (d[0] && !d[6]) r = r | 8'h40;
        if (d[1] && !d[5]) r = r | 8'h20;
        if ((r & 8'h60) != 0) r = r | 8'h80;
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", timer_status, 8'h00);
        check("R1 index", trap_index, 8'h00);
        check("R1 data", trap_data, 8'h00);
        check("R1 req", {6'b0, irq_nmi, irq_smi}, 8'h00);
        model = 8'h00;

        // R3 latches, including odd/even mapping at offsets 2 and 3
        wr(2'b10, 8'h5a); check("R3 index@2", trap_index, 8'h5a);
        wr(2'b11, 8'hc3); check("R3 data@3", trap_data, 8'hc3);
        check("R3 index kept", trap_index, 8'h5a);

        // R4, R5, R6, R7: sweep every data byte from cleared and from accumulated status
        wr(2'b00, 8'h04);
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 256; v++) begin
                if (pass == 0) begin
                    wr(2'b01, 8'h80); model = 8'h00;
                end
                wr(2'b01, 8'(v));
                model = next_status(model, 8'(v));
                check("R6 R5 R7 status", timer_status, model);
                check("R3 data", trap_data, 8'(v));
            end
        end

        // R4: offset-3 data write with index 4 leaves status
        wr(2'b01, 8'h80); wr(2'b01, 8'h01); model = 8'hc0;
        check("R6 t1", timer_status, 8'hc0);
        wr(2'b11, 8'h80);
        check("R4 offset3 ignored", timer_status, 8'hc0);
        wr(2'b11, 8'h02);
        check("R4 offset3 ignored", timer_status, 8'hc0);

        // R2 reads
        rd_chk(2'b00, 8'hc0, "R2 base");
        rd_chk(2'b01, 8'h00, "R2 off1");
        rd_chk(2'b10, 8'h00, "R2 off2");
        rd_chk(2'b11, 8'h00, "R2 off3");
        @(negedge clk); bus_addr = 2'b00; #1;
        check("R2 no strobe", bus_rdata, 8'h00);

        // R9: every index other than 4 with clear-then-start patterns
        for (int ix = 0; ix < 256; ix++) begin
            wr(2'b00, 8'(ix));
            wr(2'b01, (ix == 4) ? 8'h00 : 8'h80);
            wr(2'b01, (ix == 4) ? 8'h00 : 8'h02);
            check("R9 status", timer_status, 8'hc0);
        end

        // R8: all low control combinations
        wr(2'b00, 8'h10);
        for (int c = 0; c < 8; c++) begin
            cfg_ctrl = 8'(c);
            wr(2'b01, 8'h11);
            check("R8 pulse", {6'b0, irq_nmi, irq_smi},
                  (c[0]) ? (c[2] ? 8'h01 : 8'h02) : 8'h00);
            @(negedge clk);
            check("R8 width", {6'b0, irq_nmi, irq_smi}, 8'h00);
            wr(2'b00, 8'h10);
            check("R8 index no pulse", {6'b0, irq_nmi, irq_smi}, 8'h00);
        end
        check("R9 status after", timer_status, 8'hc0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule